// File: doc/BRIEF.md
# Bit-Stream Threshold Neuron

This block is a binary threshold neuron with eight synapses that computes on bit streams. Each input arrives as a serial stream in which the fraction of set bits encodes a value in [0, 1]. When the input is the state of another neuron, the stream is constant all-ones or all-zeros. Each synapse also receives a weight chopping stream. The synapse product is the AND of the input bit and the weight bit, so multiplication costs one gate per synapse.

A local phase counter selects one synapse product per clock cycle and feeds it to a single shared up/down counter. A per-synapse sign bit chooses the direction: 0 counts up (excitatory) and 1 counts down (inhibitory). This extends the effective weight range to [-1, 1]. The counter holds the running sum in a biased code, where the pattern 1 followed by zeros stands for zero. It is preloaded with the bias minus the threshold, so its most significant bit is set exactly when the net count has reached the threshold.

A chip-wide restart strobe marks the end of each computation cycle. With 256-bit streams and eight synapses, a computation cycle is 2048 clocks. On the strobe, the neuron captures the counter's top bit as its output and reloads the preset in the same clock.

Top module: `bitstream_neuron`

## Requirements
- R1: The product of synapse k is `in_bits[k] & wt_bits[k]`. Only a product of 1 changes the counter.
- R2: A restart cycle sets the phase to 0. On each following non-restart cycle the phase selects synapses 0, 1, ... 7 in turn and then wraps back to 0.
- R3: In a non-restart cycle whose selected product is 1, the counter moves by one step. It counts up when `sign_bits[k]` is 0 and down when it is 1. A product of 0 leaves the counter unchanged.
- R4: A restart cycle performs no accumulation. The counter is loaded with 2^(CNT_W-1) - THRESH, which is 1920 for the default of 12 bits and a threshold of 128.
- R5: In a restart cycle, `fire` takes the counter's most significant bit as it stood before the reload. At all other times `fire` holds its value.
- R6: The counter saturates at 0 and at 2^CNT_W - 1 and never wraps. A neuron that is driven far below zero therefore never reports a set top bit, and one driven past full scale still fires.
- R7: After reset, `fire` is 0, the phase is 0 and the counter holds the preset value of R4.
- R8: After a restart, the next strobe yields `fire` = 1 exactly when the up steps minus the down steps reach THRESH or more. A net count of THRESH gives 1 and a net count of THRESH-1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Global computation-cycle strobe: latch output, reload counter, clear phase |
| in_bits | input | N_IN | Current bit of each input stream |
| wt_bits | input | N_IN | Current bit of each weight chopping stream |
| sign_bits | input | N_IN | Per-synapse direction, 0 excitatory (up), 1 inhibitory (down) |
| fire | output | 1 | Latched neuron activation |

## Verification
Two events can fall in the same cycle. The first is the strobe's latch of the top bit together with the reload. The second is a selected product of 1 arriving while the counter reload is under way. The bench raises `restart` in cycles where every product is 1, and also issues back-to-back strobes. A correct design discards that product and reports the pre-reload top bit, and the per-clock reference model checks the next `fire` for both outcomes. Saturation is judged at the port: long all-up and all-down windows are followed by a strobe, because a wrapping counter would flip the latched activation.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
  // Counting direction chosen by the per-synapse sign bit.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } count_dir_e;

  // Biased preset: zero sits at 2^(w-1); subtract the threshold.
  function automatic int unsigned biased_preset(input int unsigned w, input int unsigned thr);
    return (32'd1 << (w - 1)) - thr;
  endfunction
endpackage

// File: rtl/neuron_phase_seq.sv
module neuron_phase_seq #(
  parameter int N_IN  = 8,
  localparam int SEL_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_IN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)         sel <= '0;
    else if (restart)   sel <= '0;
    else if (sel == LAST) sel <= '0;
    else                sel <= sel + 1'b1;
  end

  assert_phase_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (sel == '0));
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && sel != LAST) |=> (sel == $past(sel) + 1'b1));
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && sel == LAST) |=> (sel == '0));
endmodule

// File: rtl/neuron_synapse_mux.sv
module neuron_synapse_mux #(
  parameter int N_IN  = 8,
  localparam int SEL_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  in_bits,
  input  logic [N_IN-1:0]  wt_bits,
  input  logic [N_IN-1:0]  sign_bits,
  input  logic [SEL_W-1:0] sel,
  output logic             prod,
  output logic             down
);
  logic [N_IN-1:0] chop;

  // One AND gate per synapse performs the stream multiplication.
  for (genvar k = 0; k < N_IN; k++) begin : g_syn
    assign chop[k] = in_bits[k] & wt_bits[k];
  end

  assign prod = chop[sel];
  assign down = sign_bits[sel];
endmodule

// File: rtl/neuron_accum.sv
module neuron_accum
  import neuron_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int THRESH = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic pulse,
  input  logic down,
  output logic cnt_msb
);
  localparam logic [CNT_W-1:0] PRESET = CNT_W'(biased_preset(CNT_W, THRESH));

  logic [CNT_W-1:0] cnt;
  logic             at_floor;
  logic             at_ceil;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c, input logic dn);
    if (dn == DIR_DOWN) return (c == '0) ? c : c - 1'b1;
    else                return (c == '1) ? c : c + 1'b1;
  endfunction

  assign at_floor = (cnt == '0);
  assign at_ceil  = (cnt == '1);
  assign cnt_msb  = cnt[CNT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= PRESET;
    else if (load)  cnt <= PRESET;
    else if (pulse) cnt <= sat_step(cnt, down);
  end

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == PRESET));
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pulse) |=> $stable(cnt));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pulse && !down && at_ceil) |=> at_ceil);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pulse && down && at_floor) |=> at_floor);
endmodule

// File: rtl/bitstream_neuron.sv
module bitstream_neuron #(
  parameter int N_IN   = 8,
  parameter int CNT_W  = 12,
  parameter int THRESH = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [N_IN-1:0] in_bits,
  input  logic [N_IN-1:0] wt_bits,
  input  logic [N_IN-1:0] sign_bits,
  output logic            fire
);
  localparam int SEL_W = $clog2(N_IN);

  logic [SEL_W-1:0] sel;
  logic             prod;
  logic             down;
  logic             cnt_msb;
  logic             step_en;

  neuron_phase_seq #(.N_IN(N_IN)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sel(sel)
  );

  neuron_synapse_mux #(.N_IN(N_IN)) u_mux (
    .in_bits(in_bits), .wt_bits(wt_bits), .sign_bits(sign_bits),
    .sel(sel), .prod(prod), .down(down)
  );

  // The product is discarded in a restart cycle.
  assign step_en = prod & ~restart;

  neuron_accum #(.CNT_W(CNT_W), .THRESH(THRESH)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(restart),
    .pulse(step_en), .down(down), .cnt_msb(cnt_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       fire <= 1'b0;
    else if (restart) fire <= cnt_msb;
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prod |-> (in_bits[sel] && wt_bits[sel]));
  assert_latch_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (fire == $past(cnt_msb)));
  assert_fire_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(fire));
endmodule

// File: tb/bitstream_neuron_tb_top.sv
module bitstream_neuron_tb_top;
  localparam int N_IN   = 8;
  localparam int CNT_W  = 12;
  localparam int THRESH = 128;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int PRESET = (1 << (CNT_W - 1)) - THRESH;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            restart = 1'b0;
  logic [N_IN-1:0] in_bits = '0;
  logic [N_IN-1:0] wt_bits = '0;
  logic [N_IN-1:0] sign_bits = '0;
  logic            fire;

  int    n_vec = 0;
  int    n_bad = 0;
  int    m_cnt, m_phase, m_fire;
  string cur_req = "R7";

  always #2 clk = ~clk;

  bitstream_neuron #(.N_IN(N_IN), .CNT_W(CNT_W), .THRESH(THRESH)) dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .in_bits(in_bits), .wt_bits(wt_bits), .sign_bits(sign_bits), .fire(fire)
  );

  task automatic compare();
    n_vec++;
    if (fire !== m_fire[0]) begin
      n_bad++;
      $display("FAIL %s: fire=%0b expected=%0b at %0t", cur_req, fire, m_fire[0], $time);
    end
  endtask

  // Advance the behavioural model by one clock using the values now on the inputs.
  task automatic model_edge();
    if (!rst_n) begin
      m_cnt = PRESET; m_phase = 0; m_fire = 0;
    end else if (restart) begin
      m_fire  = (m_cnt >= (1 << (CNT_W - 1))) ? 1 : 0;
      m_cnt   = PRESET;
      m_phase = 0;
    end else begin
      if (in_bits[m_phase] && wt_bits[m_phase]) begin
        if (sign_bits[m_phase]) m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
        else                    m_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      end
      m_phase = (m_phase + 1) % N_IN;
    end
  endtask

  // Compare at the falling edge, then drive the next vector and step the model.
  task automatic cycle(input logic rs, input logic [N_IN-1:0] i, input logic [N_IN-1:0] w,
                       input logic [N_IN-1:0] s);
    @(negedge clk);
    compare();
    restart = rs; in_bits = i; wt_bits = w; sign_bits = s;
    model_edge();
  endtask

  task automatic strobe();
    cycle(1'b1, '1, '1, '0);  // products active during restart must be dropped
  endtask

  initial begin
    m_cnt = PRESET; m_phase = 0; m_fire = 0;
    // R7: reset state
    cur_req = "R7";
    repeat (3) begin @(negedge clk); model_edge(); end
    @(negedge clk); compare();
    rst_n = 1'b1;
    // One strobe right after reset: preset top bit is 0 (R7, R5)
    cycle(1'b0, '0, '0, '0);
    cur_req = "R7/R5";
    strobe();
    cycle(1'b0, '0, '0, '0);

    // R1/R3: all excitatory, random weight chops, long window -> fires
    cur_req = "R1/R3";
    for (int n = 0; n < 600; n++) cycle(1'b0, '1, N_IN'($urandom), '0);
    strobe();
    for (int n = 0; n < 600; n++) cycle(1'b0, N_IN'($urandom), N_IN'($urandom), N_IN'($urandom));
    strobe();
    // Mixed signs with excitatory bias, several windows
    for (int r = 0; r < 6; r++) begin
      for (int n = 0; n < 300 + r * 150; n++)
        cycle(1'b0, N_IN'($urandom), '1, N_IN'($urandom) & N_IN'($urandom));
      strobe();
    end

    // R2: one-hot input aligned with expected phase order
    cur_req = "R2";
    for (int n = 0; n < 200; n++) cycle(1'b0, N_IN'(1 << (n % N_IN)), '1, '0);
    strobe();
    // Misaligned one-hot (shifted by one) -> no products
    for (int n = 0; n < 400; n++) cycle(1'b0, N_IN'(1 << ((n + 1) % N_IN)), '1, '0);
    strobe();

    // R8: net count exactly THRESH, then THRESH-1
    cur_req = "R8";
    for (int n = 0; n < THRESH; n++) cycle(1'b0, '1, '1, '0);
    strobe();
    for (int n = 0; n < THRESH - 1; n++) cycle(1'b0, '1, '1, '0);
    strobe();
    for (int n = 0; n < THRESH + 20; n++) cycle(1'b0, '1, '1, N_IN'(n < 20 ? '1 : '0));
    strobe();

    // R6: saturate high then low
    cur_req = "R6";
    for (int n = 0; n < 2400; n++) cycle(1'b0, '1, '1, '0);
    strobe();
    for (int n = 0; n < 2400; n++) cycle(1'b0, '1, '1, '1);
    strobe();
    for (int n = 0; n < 40; n++) cycle(1'b0, '0, '0, '0);

    // R4/R5: back-to-back strobes and strobes with live products
    cur_req = "R4/R5";
    for (int n = 0; n < THRESH - 1; n++) cycle(1'b0, '1, '1, '0);
    strobe();
    strobe();
    strobe();
    for (int n = 0; n < THRESH; n++) cycle(1'b0, '1, '1, '0);
    strobe();
    for (int n = 0; n < 10; n++) cycle(1'b0, '1, '1, '0);

    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule